// File: doc/BRIEF.md
# Paired-Page Address Translation Buffer

This block turns virtual addresses into physical addresses through a fully associative table. Each table entry holds one virtual tag covering a pair of neighbouring pages. The entry maps the lower page of the pair and the upper page to two independent physical frames. A per-entry page mask widens both pages of the pair to a larger power-of-two size. A data port looks up the main table directly. An instruction-fetch port looks first in a two-slot micro buffer, which reloads itself from the main table when it misses.

Software uses a set of holding registers: a tag word, two frame words, a mask word, a slot pointer and a floor register. It copies these registers into the table through commands, and it can also copy a table entry back into them. A command either writes the slot named by the pointer or writes a slot picked by a free-running down-counter, which skips every slot below the floor. A search command finds the slot that holds the tag in the tag holding register.

Top module: `ptlb_top`

## Requirements
- R1: A data request in cycle t produces `d_resp`=1 in cycle t+1. If no written entry matches the request, `d_miss`=1 and `d_pa`=0. An entry matches when bits [31:13] of the address equal its tag in every bit position not covered by its mask (mask bit n covers tag bit n). When several entries match, the lowest slot wins. An instruction request that misses both the micro buffer and the table answers one cycle later with `i_miss`=1.
- R2: Let k be the number of ones in a matching entry's mask (the mask is a run of ones starting at bit 0). Address bit 12+k picks the lower frame (0) or the upper frame (1). The physical address takes the frame number shifted left by 12, with its low 12+k bits replaced by those of the virtual address.
- R3: Bit 0 of a frame word is its valid flag, and bits [20:1] hold the frame number. A match whose chosen frame has valid=0 gives `inval`=1, `miss`=0 and pa=0.
- R4: Command 0 writes the holding registers into the slot named by bits [4:0] of the pointer. Command 3 loads the tag, mask and both frame words from that slot back into the holding registers.
- R5: The replacement counter is 31 after reset and after any write of the floor register. On every other cycle it steps down by one, except that from a value at or below the floor it returns to 31. Command 1 writes the slot given by the counter's value in that cycle.
- R6: Command 2 (search) sets the pointer to the lowest matching slot with bit 31 cleared. If no slot matches, it sets the pointer to 0x8000_0000.
- R7: An instruction request that hits the micro buffer answers in the next cycle, with the translation rules of R2 and R3.
- R8: An instruction request that misses the micro buffer but hits the table gives `i_resp`=0 in the next cycle and loads the whole entry into a micro slot. A request held one more cycle then hits.
- R9: A reload replaces the micro slot that was least recently hit or reloaded.
- R10: Command 0 or command 1 empties both micro slots at the same clock edge.
- R11: After reset, no table entry matches, the holding registers read 0, the counter reads 31 and all response outputs are 0.
- R12: Holding register codes for `cfg_sel` are: 0 tag (bits [31:13]), 1 lower frame, 2 upper frame, 3 mask (bits [20:13]), 4 pointer (bit 31 search-miss, bits [4:0] slot), 5 floor (bits [4:0]), 6 counter (read only). `cfg_rdata` shows the selected register one cycle after selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Holding register write strobe |
| cfg_sel | input | 3 | Holding register code |
| cfg_wdata | input | 32 | Holding register write data |
| cfg_rdata | output | 32 | Registered read of the selected holding register |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 write at pointer, 1 write at counter, 2 search, 3 read at pointer |
| d_req | input | 1 | Data lookup request |
| d_va | input | 32 | Data virtual address |
| d_resp | output | 1 | Data response valid |
| d_miss | output | 1 | Data lookup found no entry |
| d_inval | output | 1 | Data lookup hit an invalid frame |
| d_pa | output | 32 | Data physical address |
| i_req | input | 1 | Instruction lookup request |
| i_va | input | 32 | Instruction virtual address |
| i_resp | output | 1 | Instruction response valid |
| i_miss | output | 1 | Instruction lookup found no entry |
| i_inval | output | 1 | Instruction lookup hit an invalid frame |
| i_pa | output | 32 | Instruction physical address |

## Verification
The bench goes after the pair select under a widened mask. A design that always used bit 12 would return the wrong frame for a 16 KB pair, and one that did not merge offset bits would drop address bits 12 and 13. It drives the counter against a floor of 30, where it must flip between 31 and 30. An off-by-one wrap would hand out a protected slot or get stuck at 31. It runs a three-tag fetch sequence that only passes when the reload victim is the least recently used slot, and checks that a table write forces the next fetch to stall again; a design that kept stale micro entries would answer in one cycle. It also searches for a missing tag, where a design that left the old slot number in the pointer, or forgot bit 31, would be caught.

// File: rtl/ptlb_pkg.sv
package ptlb_pkg;
  localparam int VA_W   = 32;
  localparam int OFF_W  = 12;
  localparam int PFN_W  = 20;
  localparam int MASK_W = 8;
  localparam int VPN2_W = VA_W - OFF_W - 1;
  localparam int PA_W   = PFN_W + OFF_W;
  localparam int TAG_LSB = OFF_W + 1;

  typedef enum logic [1:0] {
    OP_WR_PTR = 2'd0,
    OP_WR_RND = 2'd1,
    OP_SEARCH = 2'd2,
    OP_RD_PTR = 2'd3
  } op_e;

  // frame word: number above, valid flag in the lowest bit
  typedef struct packed {
    logic [PFN_W-1:0] pfn;
    logic             v;
  } half_t;

  typedef struct packed {
    logic              live;
    logic [VPN2_W-1:0] vpn2;
    logic [MASK_W-1:0] mask;
    half_t             lo;
    half_t             hi;
  } ent_t;

  function automatic logic tag_hit(ent_t e, logic [VPN2_W-1:0] vpn2);
    logic [VPN2_W-1:0] care;
    care = ~VPN2_W'(e.mask);
    return e.live && (((e.vpn2 ^ vpn2) & care) == '0);
  endfunction

  function automatic int unsigned mask_ones(logic [MASK_W-1:0] m);
    int unsigned n;
    n = 0;
    for (int b = 0; b < MASK_W; b++) n += int'(m[b]);
    return n;
  endfunction

  function automatic half_t pick(ent_t e, logic [VA_W-1:0] va);
    int unsigned sh;
    sh = OFF_W + mask_ones(e.mask);
    return va[sh] ? e.hi : e.lo;
  endfunction

  function automatic logic [PA_W-1:0] join_pa(half_t h, logic [MASK_W-1:0] m,
                                              logic [VA_W-1:0] va);
    logic [PA_W-1:0] keep;
    keep = (PA_W'(1) << (OFF_W + mask_ones(m))) - PA_W'(1);
    return ({h.pfn, OFF_W'(0)} & ~keep) | (PA_W'(va) & keep);
  endfunction
endpackage

// File: rtl/ptlb_cam.sv
module ptlb_cam
  import ptlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  ent_t [ENTRIES-1:0] tbl,
  input  logic [VA_W-1:0]    va,
  output logic               hit,
  output logic [IDX_W-1:0]   idx
);
  logic [ENTRIES-1:0] m;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign m[g] = tag_hit(tbl[g], va[VA_W-1:TAG_LSB]);
  end

  // lowest slot wins
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (m[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/ptlb_random.sv
module ptlb_random #(
  parameter int ENTRIES = 32,
  localparam int IDX_W = $clog2(ENTRIES),
  localparam logic [IDX_W-1:0] TOP = IDX_W'(ENTRIES - 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             floor_we,
  input  logic [IDX_W-1:0] floor_q,
  output logic [IDX_W-1:0] rnd
);
  always_ff @(posedge clk) begin
    if (rst || floor_we)      rnd <= TOP;
    else if (rnd <= floor_q)  rnd <= TOP;
    else                      rnd <= rnd - 1'b1;
  end

  a_r5_never_below: assert property (@(posedge clk) disable iff (rst)
    rnd >= floor_q);
  a_r5_step_down: assert property (@(posedge clk) disable iff (rst)
    (!floor_we && rnd > floor_q) |=> (rnd == $past(rnd) - 1'b1));
  a_r5_wrap_top: assert property (@(posedge clk) disable iff (rst)
    (!floor_we && rnd == floor_q) |=> (rnd == TOP));
endmodule

// File: rtl/ptlb_micro.sv
module ptlb_micro
  import ptlb_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            flush,
  input  logic            look_en,
  input  logic [VA_W-1:0] look_va,
  output logic            hit,
  output ent_t            hit_ent,
  input  logic            refill,
  input  ent_t            fill
);
  localparam int SLOTS = 2;

  ent_t       slot [SLOTS];
  logic [SLOTS-1:0] m;
  logic       way;
  logic       lru;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    assign m[g] = tag_hit(slot[g], look_va[VA_W-1:TAG_LSB]);
  end

  assign hit     = |m;
  assign way     = !m[0];
  assign hit_ent = slot[way];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      for (int s = 0; s < SLOTS; s++) slot[s] <= '0;
      lru <= 1'b0;
    end else if (refill) begin
      slot[lru] <= fill;
      lru       <= !lru;
    end else if (look_en && hit) begin
      lru <= !way;
    end
  end

  a_r10_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> (!slot[0].live && !slot[1].live));
  a_r9_victim_rotates: assert property (@(posedge clk) disable iff (rst)
    (refill && !flush) |=> (lru != $past(lru)));
endmodule

// File: rtl/ptlb_top.sv
module ptlb_top
  import ptlb_pkg::*;
#(
  parameter int ENTRIES = 32,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [VA_W-1:0]   cfg_wdata,
  output logic [VA_W-1:0]   cfg_rdata,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic              d_req,
  input  logic [VA_W-1:0]   d_va,
  output logic              d_resp,
  output logic              d_miss,
  output logic              d_inval,
  output logic [PA_W-1:0]   d_pa,
  input  logic              i_req,
  input  logic [VA_W-1:0]   i_va,
  output logic              i_resp,
  output logic              i_miss,
  output logic              i_inval,
  output logic [PA_W-1:0]   i_pa
);
  ent_t [ENTRIES-1:0] tbl;

  logic [VPN2_W-1:0] st_vpn2;
  logic [MASK_W-1:0] st_mask;
  half_t             st_lo, st_hi;
  logic              st_miss;
  logic [IDX_W-1:0]  st_idx, st_floor, rnd;

  logic             d_hit, c_hit, p_hit, u_hit;
  logic [IDX_W-1:0] d_idx, c_idx, p_idx;
  ent_t             d_ent, c_ent, u_ent;
  half_t            d_half, u_half;
  logic             floor_we, flush, refill;
  op_e              op;

  assign op       = op_e'(cmd_op);
  assign floor_we = cfg_we && (cfg_sel == 3'd5);
  assign flush    = cmd_valid && (op == OP_WR_PTR || op == OP_WR_RND);

  ptlb_cam #(.ENTRIES(ENTRIES)) u_dcam (.tbl(tbl), .va(d_va), .hit(d_hit), .idx(d_idx));
  ptlb_cam #(.ENTRIES(ENTRIES)) u_icam (.tbl(tbl), .va(i_va), .hit(c_hit), .idx(c_idx));
  ptlb_cam #(.ENTRIES(ENTRIES)) u_pcam (.tbl(tbl), .va({st_vpn2, TAG_LSB'(0)}),
                                        .hit(p_hit), .idx(p_idx));

  ptlb_random #(.ENTRIES(ENTRIES)) u_rnd (
    .clk(clk), .rst(rst), .floor_we(floor_we), .floor_q(st_floor), .rnd(rnd));

  assign refill = i_req && !u_hit && c_hit;
  assign c_ent  = tbl[c_idx];

  ptlb_micro u_micro (
    .clk(clk), .rst(rst), .flush(flush), .look_en(i_req), .look_va(i_va),
    .hit(u_hit), .hit_ent(u_ent), .refill(refill), .fill(c_ent));

  assign d_ent  = tbl[d_idx];
  assign d_half = pick(d_ent, d_va);
  assign u_half = pick(u_ent, i_va);

  // table and holding registers
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < ENTRIES; e++) tbl[e] <= '0;
      st_vpn2  <= '0;
      st_mask  <= '0;
      st_lo    <= '0;
      st_hi    <= '0;
      st_miss  <= 1'b0;
      st_idx   <= '0;
      st_floor <= '0;
    end else begin
      if (cmd_valid) begin
        case (op)
          OP_WR_PTR: tbl[st_idx] <= '{live: 1'b1, vpn2: st_vpn2, mask: st_mask,
                                     lo: st_lo, hi: st_hi};
          OP_WR_RND: tbl[rnd]    <= '{live: 1'b1, vpn2: st_vpn2, mask: st_mask,
                                     lo: st_lo, hi: st_hi};
          OP_SEARCH: begin
            st_miss <= !p_hit;
            st_idx  <= p_hit ? p_idx : '0;
          end
          OP_RD_PTR: begin
            st_vpn2 <= tbl[st_idx].vpn2;
            st_mask <= tbl[st_idx].mask;
            st_lo   <= tbl[st_idx].lo;
            st_hi   <= tbl[st_idx].hi;
          end
          default: ;
        endcase
      end
      if (cfg_we) begin
        case (cfg_sel)
          3'd0: st_vpn2  <= cfg_wdata[VA_W-1:TAG_LSB];
          3'd1: st_lo    <= half_t'(cfg_wdata[PFN_W:0]);
          3'd2: st_hi    <= half_t'(cfg_wdata[PFN_W:0]);
          3'd3: st_mask  <= cfg_wdata[TAG_LSB+MASK_W-1:TAG_LSB];
          3'd4: begin
            st_miss <= cfg_wdata[VA_W-1];
            st_idx  <= cfg_wdata[IDX_W-1:0];
          end
          3'd5: st_floor <= cfg_wdata[IDX_W-1:0];
          default: ;
        endcase
      end
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else begin
      case (cfg_sel)
        3'd0:    cfg_rdata <= VA_W'(st_vpn2) << TAG_LSB;
        3'd1:    cfg_rdata <= VA_W'(st_lo);
        3'd2:    cfg_rdata <= VA_W'(st_hi);
        3'd3:    cfg_rdata <= VA_W'(st_mask) << TAG_LSB;
        3'd4:    cfg_rdata <= {st_miss, (VA_W-1)'(st_idx)};
        3'd5:    cfg_rdata <= VA_W'(st_floor);
        3'd6:    cfg_rdata <= VA_W'(rnd);
        default: cfg_rdata <= '0;
      endcase
    end
  end

  // registered lookup results
  always_ff @(posedge clk) begin
    if (rst) begin
      d_resp <= 1'b0; d_miss <= 1'b0; d_inval <= 1'b0; d_pa <= '0;
      i_resp <= 1'b0; i_miss <= 1'b0; i_inval <= 1'b0; i_pa <= '0;
    end else begin
      d_resp  <= d_req;
      d_miss  <= d_req && !d_hit;
      d_inval <= d_req && d_hit && !d_half.v;
      d_pa    <= (d_req && d_hit && d_half.v) ? join_pa(d_half, d_ent.mask, d_va) : '0;
      i_resp  <= i_req && (u_hit || !c_hit);
      i_miss  <= i_req && !u_hit && !c_hit;
      i_inval <= i_req && u_hit && !u_half.v;
      i_pa    <= (i_req && u_hit && u_half.v) ? join_pa(u_half, u_ent.mask, i_va) : '0;
    end
  end

  a_r1_answer_next: assert property (@(posedge clk) disable iff (rst)
    d_req |=> d_resp);
  a_r3_fault_exclusive: assert property (@(posedge clk) disable iff (rst)
    d_resp |-> !(d_miss && d_inval));
  a_r6_search_miss: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && op == OP_SEARCH && !p_hit && !cfg_we) |=> st_miss);
  a_r8_reload_stall: assert property (@(posedge clk) disable iff (rst)
    refill |=> !i_resp);
endmodule

// File: tb/ptlb_top_tb_top.sv
`timescale 1ns/1ps
module ptlb_top_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        cfg_we = 0, cmd_valid = 0, d_req = 0, i_req = 0;
  logic [2:0]  cfg_sel = 0;
  logic [1:0]  cmd_op = 0;
  logic [31:0] cfg_wdata = 0, d_va = 0, i_va = 0;
  logic [31:0] cfg_rdata, d_pa, i_pa;
  logic        d_resp, d_miss, d_inval, i_resp, i_miss, i_inval;

  ptlb_top dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .d_req(d_req), .d_va(d_va), .d_resp(d_resp), .d_miss(d_miss), .d_inval(d_inval),
    .d_pa(d_pa), .i_req(i_req), .i_va(i_va), .i_resp(i_resp), .i_miss(i_miss),
    .i_inval(i_inval), .i_pa(i_pa));

  int total = 0, bad = 0, wd = 0;

  task automatic check(input string tag, input string what,
                       input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  // ---------------- reference model ----------------
  bit          m_live [32];
  logic [18:0] m_vpn2 [32];
  logic [7:0]  m_mask [32];
  logic [20:0] m_w0 [32], m_w1 [32];
  logic [18:0] s_vpn2;
  logic [7:0]  s_mask;
  logic [20:0] s_w0, s_w1;
  bit          s_miss;
  logic [4:0]  s_idx, s_floor, s_rnd;
  bit          u_live [2];
  int          u_src [2];
  logic [18:0] u_vpn2 [2];
  logic [7:0]  u_mask [2];
  logic [20:0] u_w0 [2], u_w1 [2];
  bit          u_lru;
  logic [31:0] e_rdata, e_dpa, e_ipa;
  bit          e_dresp, e_dmiss, e_dinval, e_iresp, e_imiss, e_iinval;
  bit          armed = 0;

  function automatic bit tmatch(logic [18:0] tv, logic [7:0] mk, logic [18:0] v);
    return ((tv ^ v) & ~{11'b0, mk}) == 19'd0;
  endfunction

  function automatic int find(logic [18:0] v);
    for (int i = 0; i < 32; i++)
      if (m_live[i] && tmatch(m_vpn2[i], m_mask[i], v)) return i;
    return -1;
  endfunction

  task automatic xl(input logic [7:0] mk, input logic [20:0] w0, input logic [20:0] w1,
                    input logic [31:0] va, output bit v, output logic [31:0] pa);
    int k;
    longint lim;
    logic [20:0] w;
    k   = $countones(mk);
    lim = longint'(1) << (12 + k);
    w   = va[12+k] ? w1 : w0;
    v   = w[0];
    pa  = v ? 32'((longint'(w[20:1]) * 4096) / lim * lim + longint'(va) % lim) : 32'd0;
  endtask

  task automatic model_reset();
    for (int i = 0; i < 32; i++) begin
      m_live[i] = 0; m_vpn2[i] = 0; m_mask[i] = 0; m_w0[i] = 0; m_w1[i] = 0;
    end
    s_vpn2 = 0; s_mask = 0; s_w0 = 0; s_w1 = 0; s_miss = 0; s_idx = 0;
    s_floor = 0; s_rnd = 31; u_live[0] = 0; u_live[1] = 0; u_lru = 0;
    e_rdata = 0; e_dpa = 0; e_ipa = 0;
    {e_dresp, e_dmiss, e_dinval, e_iresp, e_imiss, e_iinval} = '0;
  endtask

  task automatic model_step();
    int j, ui, pj;
    bit v, flush;
    logic [4:0] nr;
    logic [31:0] pa;
    armed = 1;
    if (rst) begin model_reset(); return; end
    case (cfg_sel)
      3'd0: e_rdata = {s_vpn2, 13'd0};
      3'd1: e_rdata = {11'd0, s_w0};
      3'd2: e_rdata = {11'd0, s_w1};
      3'd3: e_rdata = {11'd0, s_mask, 13'd0};
      3'd4: e_rdata = {s_miss, 26'd0, s_idx};
      3'd5: e_rdata = {27'd0, s_floor};
      3'd6: e_rdata = {27'd0, s_rnd};
      default: e_rdata = 0;
    endcase
    e_dresp = d_req; e_dmiss = 0; e_dinval = 0; e_dpa = 0;
    if (d_req) begin
      j = find(d_va[31:13]);
      if (j < 0) e_dmiss = 1;
      else begin
        xl(m_mask[j], m_w0[j], m_w1[j], d_va, v, pa);
        e_dinval = !v; e_dpa = pa;
      end
    end
    ui = -1;
    for (int u = 1; u >= 0; u--)
      if (u_live[u] && tmatch(u_vpn2[u], u_mask[u], i_va[31:13])) ui = u;
    pj = -1;
    e_iresp = 0; e_imiss = 0; e_iinval = 0; e_ipa = 0;
    if (i_req) begin
      if (ui >= 0) begin
        xl(u_mask[ui], u_w0[ui], u_w1[ui], i_va, v, pa);
        e_iresp = 1; e_iinval = !v; e_ipa = pa;
      end else begin
        pj = find(i_va[31:13]);
        if (pj < 0) begin e_iresp = 1; e_imiss = 1; end
      end
    end
    if (cfg_we && cfg_sel == 3'd5) nr = 31;
    else if (s_rnd <= s_floor)     nr = 31;
    else                           nr = s_rnd - 1;
    flush = cmd_valid && (cmd_op == 2'd0 || cmd_op == 2'd1);
    if (flush) begin
      u_live[0] = 0; u_live[1] = 0; u_lru = 0;
    end else if (pj >= 0) begin
      u_live[u_lru] = 1; u_vpn2[u_lru] = m_vpn2[pj]; u_mask[u_lru] = m_mask[pj];
      u_w0[u_lru] = m_w0[pj]; u_w1[u_lru] = m_w1[pj]; u_lru = !u_lru;
    end else if (i_req && ui >= 0) begin
      u_lru = (ui == 0);
    end
    if (cmd_valid) begin
      case (cmd_op)
        2'd0, 2'd1: begin
          j = (cmd_op == 2'd0) ? int'(s_idx) : int'(s_rnd);
          m_live[j] = 1; m_vpn2[j] = s_vpn2; m_mask[j] = s_mask;
          m_w0[j] = s_w0; m_w1[j] = s_w1;
        end
        2'd2: begin
          j = find(s_vpn2);
          s_miss = (j < 0);
          s_idx  = (j < 0) ? 5'd0 : 5'(j);
        end
        default: begin
          s_vpn2 = m_vpn2[s_idx]; s_mask = m_mask[s_idx];
          s_w0 = m_w0[s_idx]; s_w1 = m_w1[s_idx];
        end
      endcase
    end
    if (cfg_we) begin
      case (cfg_sel)
        3'd0: s_vpn2 = cfg_wdata[31:13];
        3'd1: s_w0 = cfg_wdata[20:0];
        3'd2: s_w1 = cfg_wdata[20:0];
        3'd3: s_mask = cfg_wdata[20:13];
        3'd4: begin s_miss = cfg_wdata[31]; s_idx = cfg_wdata[4:0]; end
        3'd5: s_floor = cfg_wdata[4:0];
        default: ;
      endcase
    end
    s_rnd = nr;
  endtask

  always @(posedge clk) model_step();

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (armed) begin
      check((cfg_sel == 3'd6) ? "R5" : "R12", "cfg_rdata", cfg_rdata, e_rdata);
      check("R1", "d_resp", 32'(d_resp), 32'(e_dresp));
      check("R1", "d_miss", 32'(d_miss), 32'(e_dmiss));
      check("R3", "d_inval", 32'(d_inval), 32'(e_dinval));
      check("R2", "d_pa", d_pa, e_dpa);
      check("R8", "i_resp", 32'(i_resp), 32'(e_iresp));
      check("R1", "i_miss", 32'(i_miss), 32'(e_imiss));
      check("R3", "i_inval", 32'(i_inval), 32'(e_iinval));
      check("R7", "i_pa", i_pa, e_ipa);
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 20000) begin
      total++; bad++;
      $display("FAIL R1 watchdog expired got=%0d exp=<20000", wd);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [2:0] sel, input logic [31:0] val);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic cmd(input logic [1:0] o);
    cmd_valid = 1; cmd_op = o;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic rd(input logic [2:0] sel, output logic [31:0] val);
    cfg_sel = sel;
    @(negedge clk);
    val = cfg_rdata;
  endtask

  task automatic dlook(input logic [31:0] va, output logic [31:0] pa,
                       output bit miss, output bit inval);
    d_req = 1; d_va = va;
    @(negedge clk);
    d_req = 0;
    pa = d_pa; miss = d_miss; inval = d_inval;
  endtask

  task automatic fetch(input logic [31:0] va, input int exp_lat, input string tag);
    int n;
    n = 0;
    i_req = 1; i_va = va;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      n++;
      if (i_resp) break;
    end
    i_req = 0;
    check(tag, "fetch latency", 32'(n), 32'(exp_lat));
  endtask

  task automatic put(input logic [31:0] tag, input logic [31:0] w0, input logic [31:0] w1,
                     input logic [31:0] mk, input logic [31:0] slot);
    wr(3'd0, tag); wr(3'd1, w0); wr(3'd2, w1); wr(3'd3, mk); wr(3'd4, slot);
    cmd(2'd0);
  endtask

  initial begin
    logic [31:0] r, pa;
    bit mi, iv;
    cfg_sel = 3'd6;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R11", "counter after reset", cfg_rdata, 32'd31);
    check("R11", "d_resp after reset", 32'(d_resp), 32'd0);
    dlook(32'h0000_0000, pa, mi, iv);
    check("R11", "empty table misses", 32'(mi), 32'd1);
    rd(3'd0, r);
    check("R11", "tag register reset", r, 32'd0);

    wr(3'd3, 32'h0000_6000); rd(3'd3, r);
    check("R12", "mask readback", r, 32'h0000_6000);
    wr(3'd4, 32'h8000_0003); rd(3'd4, r);
    check("R12", "pointer readback", r, 32'h8000_0003);

    put(32'h0002_0000, 32'h0000_1555, 32'h0000_1776, 32'h0, 32'd0);
    put(32'h0040_0000, 32'h0002_4681, 32'h000A_CF01, 32'h0000_6000, 32'd1);
    put(32'h0100_0000, 32'h0000_0EEF, 32'h0, 32'h0, 32'd3);

    dlook(32'h0002_0123, pa, mi, iv);
    check("R2", "lower frame 4K", pa, 32'h00AA_A123);
    dlook(32'h0002_1456, pa, mi, iv);
    check("R3", "invalid upper frame", {30'd0, mi, iv}, 32'd1);
    dlook(32'h0040_5ABC, pa, mi, iv);
    check("R2", "upper frame 16K", pa, 32'h5678_1ABC);
    dlook(32'h0040_2000, pa, mi, iv);
    check("R2", "lower frame 16K", pa, 32'h1234_2000);
    dlook(32'h0080_0000, pa, mi, iv);
    check("R1", "unmapped address", {30'd0, mi, iv}, 32'd2);

    wr(3'd0, 32'h0040_0000); cmd(2'd2); rd(3'd4, r);
    check("R6", "search hit slot", r, 32'd1);
    wr(3'd0, 32'h0080_0000); cmd(2'd2); rd(3'd4, r);
    check("R6", "search miss flag", r, 32'h8000_0000);

    wr(3'd4, 32'd0); cmd(2'd3); rd(3'd2, r);
    check("R4", "read back upper frame", r, 32'h0000_1776);
    rd(3'd0, r);
    check("R4", "read back tag", r, 32'h0002_0000);

    fetch(32'h0002_0010, 2, "R8");
    fetch(32'h0002_0010, 1, "R7");
    fetch(32'h0002_1010, 1, "R3");
    fetch(32'h0040_5000, 2, "R8");
    fetch(32'h0002_0010, 1, "R9");
    fetch(32'h0100_0000, 2, "R9");
    fetch(32'h0002_0010, 1, "R9");
    fetch(32'h0040_5000, 2, "R9");
    fetch(32'h0080_0000, 1, "R1");

    wr(3'd4, 32'd3); cmd(2'd0);
    fetch(32'h0002_0010, 2, "R10");

    wr(3'd5, 32'd30);
    rd(3'd6, r); check("R5", "counter after floor write", r, 32'd31);
    rd(3'd6, r); check("R5", "counter steps to floor", r, 32'd30);
    rd(3'd6, r); check("R5", "counter wraps to top", r, 32'd31);

    wr(3'd5, 32'd2);
    put(32'h0200_0000, 32'h3, 32'h3, 32'h0, 32'd0);
    wr(3'd0, 32'h0200_0000); cmd(2'd1);
    wr(3'd0, 32'h0300_0000); cmd(2'd1);
    wr(3'd0, 32'h0300_0000); cmd(2'd2); rd(3'd4, r);
    check("R5", "random write above floor", 32'(r >= 32'd2 && r <= 32'd31), 32'd1);
    dlook(32'h0200_0000, pa, mi, iv);
    check("R5", "floor slot kept", pa, 32'h0000_1000);

    repeat (3) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule